// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the word address for a four-beat burst in a synchronous cache memory. Two active-low start strobes each capture the address bus. The low two bits seed a burst index, and the upper bits go into a holding register that stays fixed until the next start. On each rising edge where the active-low step input is sampled low and no strobe is active, the sequencer moves to the next beat. After the fourth beat it wraps back to the start.

The low bits follow one of two orders, chosen by the order-select input when the burst begins. Linear order counts upward modulo four from the start bits. Interleaved order XORs the start bits with the beat number. A strobe that arrives during a burst abandons that burst and loads a new start address. A strobe also wins over the step input on the same edge. A synchronous reset clears the whole state.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `beat_o` = 0 and `addr_o` = 0, and the order becomes linear.
- R2: When `start_p_n` is sampled low, the next cycle shows `addr_o` equal to the sampled `addr_i` and `beat_o` = 0.
- R3: When `start_c_n` is sampled low, the next cycle shows `addr_o` equal to the sampled `addr_i` and `beat_o` = 0.
- R4: With both strobes high and `step_n` sampled low, `beat_o` goes up by one modulo 4, so it returns to 0 after four steps.
- R5: In linear order (`order_i` = 0 at load), `addr_o[1:0]` equals (start + beat) mod 4.
- R6: In interleaved order (`order_i` = 1 at load), `addr_o[1:0]` equals start XOR beat.
- R7: `step_n` has no effect on an edge where a strobe is active, so `beat_o` is 0 after that load.
- R8: With both strobes high and `step_n` high, `addr_o` and `beat_o` keep their values.
- R9: `addr_o[ADDR_W-1:2]` keeps the value loaded at burst start until the next strobe or reset.
- R10: A strobe during a burst ends it and loads the new address, even when `step_n` is low on the same edge.
- R11: The order is fixed at load. Changes on `order_i` between strobes have no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Start address, sampled while a strobe is active |
| start_p_n | input | 1 | First start strobe, active low |
| start_c_n | input | 1 | Second start strobe, active low |
| step_n | input | 1 | Advance to next beat, active low |
| order_i | input | 1 | Order select at load: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current word address |
| beat_o | output | 2 | Beat index within the burst (0..3) |

## Verification
A corrupted beat counter shows up on `beat_o` and in the low bits of `addr_o` one cycle after the faulty edge. An order flag that drifts after load shows up at the next non-zero beat, because the two orders give different low bits for starts 1 and 3 at beats 1 and 3. A holding register that loses its value changes the upper bits of `addr_o` immediately. The bench therefore compares every beat of every start value in both orders, including held cycles and cycles where the order input is toggled mid-burst.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter
    import bsq_pkg::*;
#(
    parameter int BW = BEAT_W
) (
    input  logic          load,
    input  logic          step,
    input  logic [BW-1:0] beat_q,
    output logic [BW-1:0] beat_d
);
    localparam logic [BW-1:0] ONE = BW'(1);

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d = '0;
        end else if (step) begin
            beat_d = beat_q + ONE;
        end
    end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
    import bsq_pkg::*;
#(
    parameter int BW = BEAT_W
) (
    input  order_e        ord,
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] beat,
    output logic [BW-1:0] low
);
    logic [BW-1:0] lin_d;
    logic [BW-1:0] ilv_d;

    always_comb begin
        lin_d = start + beat;
    end

    for (genvar i = 0; i < BW; i++) begin : g_ilv
        assign ilv_d[i] = start[i] ^ beat[i];
    end

    always_comb begin
        low = (ord == ORD_INTERLEAVED) ? ilv_d : lin_d;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_p_n,
    input  logic              start_c_n,
    input  logic              step_n,
    input  logic              order_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start;
        logic [BEAT_W-1:0]  beat;
        order_e             ord;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic load_d, step_d;
    logic [BEAT_W-1:0] beat_d;
    logic [BEAT_W-1:0] low_d;

    always_comb begin
        load_d = !start_p_n || !start_c_n;
        step_d = !step_n;
    end

    bsq_beat_counter #(.BW(BEAT_W)) u_cnt (
        .load   (load_d),
        .step   (step_d),
        .beat_q (st_q.beat),
        .beat_d (beat_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.beat = beat_d;
        if (load_d) begin
            st_d.upper = addr_i[ADDR_W-1:BEAT_W];
            st_d.start = addr_i[BEAT_W-1:0];
            st_d.ord   = order_e'(order_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bsq_order_map #(.BW(BEAT_W)) u_map (
        .ord   (st_q.ord),
        .start (st_q.start),
        .beat  (st_q.beat),
        .low   (low_d)
    );

    always_comb begin
        addr_o = {st_q.upper, low_d};
        beat_o = st_q.beat;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (beat_o == '0 && addr_o == '0));

    assert_load_captures_R2: assert property (@(posedge clk) disable iff (rst)
        (!start_p_n || !start_c_n) |=> (beat_o == '0 && addr_o == $past(addr_i)));

    assert_step_increments_R4: assert property (@(posedge clk) disable iff (rst)
        (start_p_n && start_c_n && !step_n) |=> (beat_o == BEAT_W'($past(beat_o) + 1)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (start_p_n && start_c_n && step_n) |=> ($stable(addr_o) && $stable(beat_o)));

    assert_upper_held_R9: assert property (@(posedge clk) disable iff (rst)
        (start_p_n && start_c_n) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    assert_beat0_is_start_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_o == '0) |-> (addr_o[BEAT_W-1:0] == st_q.start));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          start_p_n = 1'b1;
    logic          start_c_n = 1'b1;
    logic          step_n = 1'b1;
    logic          order_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr_i(addr_i), .start_p_n(start_p_n),
        .start_c_n(start_c_n), .step_n(step_n), .order_i(order_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    function automatic logic [1:0] exp_low(input bit ilv, input logic [1:0] s, input int n);
        if (ilv) return s ^ 2'(n);
        return 2'((int'(s) + n) % 4);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit r, input bit sp, input bit sc, input bit st,
                       input logic [AW-1:0] a, input bit m);
        @(negedge clk);
        rst = r; start_p_n = sp; start_c_n = sc; step_n = st; addr_i = a; order_i = m;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_addr(input string req, input logic [AW-1:0] exp, input logic [1:0] eb);
        chk(addr_o == exp, req, addr_o, exp);
        chk(beat_o == eb, req, AW'(beat_o), AW'(eb));
    endtask

    initial begin
        logic [AW-1:0] ups [3];
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        ups[0] = '0; ups[1] = 16'h2A5C; ups[2] = 16'hFFFC;

        cyc(1, 1, 1, 1, 16'h1234, 0);
        cyc(1, 1, 1, 0, 16'h1234, 1);
        chk_addr("R1", '0, 2'd0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    a = ups[u] | AW'(s);
                    // R7: step_n low on the load edge is ignored
                    if (s % 2 == 0) begin
                        cyc(0, 0, 1, 0, a, m[0]);
                        chk_addr("R2 R7", a, 2'd0);
                    end else begin
                        cyc(0, 1, 0, 0, a, m[0]);
                        chk_addr("R3 R7", a, 2'd0);
                    end
                    for (int n = 1; n <= 4; n++) begin
                        if (n == 2) begin
                            cyc(0, 1, 1, 1, ~a, !m[0]);
                            chk_addr("R8 R11", {a[AW-1:2], exp_low(m[0], 2'(s), 1)}, 2'd1);
                        end
                        // R11: order_i toggled against the loaded order
                        cyc(0, 1, 1, 0, ~a, !m[0]);
                        chk_addr(m == 0 ? "R4 R5 R9 R11" : "R4 R6 R9 R11",
                                 {a[AW-1:2], exp_low(m[0], 2'(s), n % 4)}, 2'(n % 4));
                    end
                end
            end
        end

        // R10: reload mid-burst with step_n low on the same edge
        a = 16'h5551;
        b = 16'hC3A2;
        cyc(0, 1, 0, 1, a, 1);
        cyc(0, 1, 1, 0, '0, 0);
        cyc(0, 1, 1, 0, '0, 0);
        chk_addr("R6", {a[AW-1:2], 2'b11}, 2'd2);
        cyc(0, 0, 1, 0, b, 0);
        chk_addr("R10", b, 2'd0);
        cyc(0, 1, 1, 0, '0, 1);
        chk_addr("R10 R5", {b[AW-1:2], 2'b11}, 2'd1);
        cyc(0, 0, 0, 0, a, 0);
        chk_addr("R10 R2 R3", a, 2'd0);

        // R1: reset mid-burst, even with a strobe active
        cyc(0, 1, 1, 0, '0, 1);
        cyc(1, 0, 1, 0, b, 1);
        chk_addr("R1", '0, 2'd0);
        cyc(0, 1, 1, 0, '0, 1);
        chk_addr("R1 R5", AW'(1), 2'd1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule